// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer

This engine is the lowest layer of a master for a single-wire, open-drain bus. A command starts one of four timed slots: a bus reset with presence detect, a write of a 1, a write of a 0, or a read. During a slot the engine pulls the line low by asserting a drive enable, and releases it by dropping that enable. It samples the synchronized line level at a fixed point and finishes with a one-cycle done strobe. The returned bit and presence flag are held until a later slot replaces them.

All slot timing comes from a chain of counters. A prescaler divides the clock down to one microsecond. A run-time scale factor then stretches each microsecond into one time unit, and a phase counter counts units through three phases: drive low, wait to the sample point, and tail. Byte assembly, CRC, addressing and device search belong to logic above this block.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset, busy, done, line_oe, rx_bit and presence are all 0.
- R2: A write command (cmd_op 2'b01) with cmd_bit 1 drives the line low for 6 units and then releases it for 64 units. The slot lasts 70 units and returns rx_bit 0.
- R3: A write command with cmd_bit 0 drives the line low for 60 units and then releases it for 10 units. The slot lasts 70 units and returns rx_bit 0.
- R4: A read command (cmd_op 2'b10) drives the line low for 6 units and then releases it. The line is sampled 9 units after release, and the slot ends 55 units after the sample. rx_bit returns the sampled level.
- R5: A reset command (cmd_op 2'b00) drives the line low for 500 units and samples the line 70 units after release. presence is 1 when the sample is low and 0 when it is high. A further 430 units of recovery follow before done, and rx_bit is left unchanged.
- R6: A touch command (cmd_op 2'b11) with cmd_bit 1 runs a read slot and returns the sampled level. With cmd_bit 0 it runs a write-0 slot and returns 0.
- R7: One unit is CLK_PER_US clock cycles multiplied by the scale input. A scale of 0 counts as 1. The scale is captured when the command is accepted, so later changes to the input do not affect the running slot.
- R8: A command is accepted only when cmd_valid is high while busy is low. busy stays high from the cycle after acceptance until the slot ends. When busy falls, done is high for exactly that one cycle. Commands offered while busy are ignored and produce no extra slot.
- R9: line_oe is high only during the drive-low phase of a slot. It is never high while idle.
- R10: line_in passes through a two-flop synchronizer before it is sampled. presence changes only during reset slots, and rx_bit changes only during the other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scale | input | SCALE_W | Run-time timing multiplier, captured at accept; 0 counts as 1 |
| cmd_valid | input | 1 | Command offer |
| cmd_op | input | 2 | 00 reset, 01 write, 10 read, 11 touch |
| cmd_bit | input | 1 | Bit for write and touch |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle end-of-slot strobe |
| rx_bit | output | 1 | Result bit of the last non-reset slot |
| presence | output | 1 | Device answered the last reset |
| line_oe | output | 1 | Drive enable; high pulls the line low |
| line_in | input | 1 | Line level as seen by the master |

## Verification
The assertions assume that line_in is a real open-drain level. In particular, the line reads low whenever line_oe is high. They also assume that cmd_valid may be offered at any time and that it is simply dropped while a slot runs. The bench models the pull-up and a responding device as a low window measured from the start of each slot. It places every window edge many cycles away from the sample point, so the two-flop delay never makes a result ambiguous. The bench also changes the scale input and offers stray commands in the middle of slots, which stays within the assumptions the assertions make.

// File: rtl/owire_slot_engine.sv
module owire_slot_engine #(
  parameter int CLK_PER_US = 50,
  parameter int SCALE_W    = 4,
  parameter int W1_LOW     = 6,
  parameter int W1_REL     = 64,
  parameter int W0_LOW     = 60,
  parameter int W0_REL     = 10,
  parameter int RD_LOW     = 6,
  parameter int RD_SMP     = 9,
  parameter int RD_TAIL    = 55,
  parameter int RS_LOW     = 500,
  parameter int RS_SMP     = 70,
  parameter int RS_REC     = 430
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCALE_W-1:0] scale,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_bit,
  output logic               busy,
  output logic               done,
  output logic               rx_bit,
  output logic               presence,
  output logic               line_oe,
  input  logic               line_in
);
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXLEN = mx(mx(mx(W1_LOW, W1_REL), mx(W0_LOW, W0_REL)),
                             mx(mx(mx(RD_LOW, RD_SMP), RD_TAIL), mx(mx(RS_LOW, RS_SMP), RS_REC)));
  localparam int LW = $clog2(MAXLEN + 1);
  localparam int PW = $clog2(CLK_PER_US + 1);

  localparam logic [1:0] OP_RST = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_TAIL} st_t;

  st_t               st;
  logic              k_rst, k_rd;
  logic [LW-1:0]     ph_cnt, wait_len, tail_len;
  logic [LW-1:0]     n_low, n_wait, n_tail;
  logic [PW-1:0]     us_cnt;
  logic [SCALE_W-1:0] sc_cnt, scl;
  logic              s1, s2;
  logic              us_tick, unit_tick, last;
  logic              c_rst, c_rd;

  assign c_rst = (cmd_op == OP_RST);
  assign c_rd  = (cmd_op == OP_RD) || (cmd_op == 2'b11 && cmd_bit);

  always_comb begin
    if (c_rst) begin
      n_low = LW'(RS_LOW); n_wait = LW'(RS_SMP); n_tail = LW'(RS_REC);
    end else if (c_rd) begin
      n_low = LW'(RD_LOW); n_wait = LW'(RD_SMP); n_tail = LW'(RD_TAIL);
    end else if (cmd_op == OP_WR && cmd_bit) begin
      n_low = LW'(W1_LOW); n_wait = LW'(W1_REL); n_tail = '0;
    end else begin
      n_low = LW'(W0_LOW); n_wait = LW'(W0_REL); n_tail = '0;
    end
  end

  assign us_tick   = (us_cnt == PW'(CLK_PER_US - 1));
  assign unit_tick = us_tick && (sc_cnt == scl - 1'b1);
  assign last      = unit_tick && (ph_cnt == LW'(1));
  assign busy      = (st != S_IDLE);
  assign line_oe   = (st == S_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      k_rst    <= 1'b0;
      k_rd     <= 1'b0;
      ph_cnt   <= '0;
      wait_len <= '0;
      tail_len <= '0;
      us_cnt   <= '0;
      sc_cnt   <= '0;
      scl      <= '0;
      s1       <= 1'b1;
      s2       <= 1'b1;
      done     <= 1'b0;
      rx_bit   <= 1'b0;
      presence <= 1'b0;
    end else begin
      done <= 1'b0;
      s1   <= line_in;
      s2   <= s1;
      if (st == S_IDLE) begin
        if (cmd_valid) begin
          st       <= S_LOW;
          k_rst    <= c_rst;
          k_rd     <= c_rd;
          ph_cnt   <= n_low;
          wait_len <= n_wait;
          tail_len <= n_tail;
          us_cnt   <= '0;
          sc_cnt   <= '0;
          scl      <= (scale == '0) ? SCALE_W'(1) : scale;
        end
      end else begin
        us_cnt <= us_tick ? '0 : us_cnt + 1'b1;
        if (us_tick) sc_cnt <= (sc_cnt == scl - 1'b1) ? '0 : sc_cnt + 1'b1;
        if (unit_tick) ph_cnt <= ph_cnt - 1'b1;
        if (last) begin
          case (st)
            S_LOW: begin
              st     <= S_WAIT;
              ph_cnt <= wait_len;
            end
            S_WAIT: begin
              if (k_rst) presence <= ~s2;
              else       rx_bit   <= k_rd ? s2 : 1'b0;
              if (tail_len == '0) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                st     <= S_TAIL;
                ph_cnt <= tail_len;
              end
            end
            default: begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

module owire_slot_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic rx_bit,
  input logic presence,
  input logic line_oe
);
  assert_drive_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> busy);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);
  assert_presence_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presence) |-> $past(busy));
  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> $past(busy));
endmodule

bind owire_slot_engine owire_slot_engine_chk u_chk (.*);

// File: tb/owire_slot_engine_tb.sv
module owire_slot_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int KUS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] scale = 4'd1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_bit = 1'b0;
  logic busy, done, rx_bit, presence, line_oe, line_in, dev_low;
  int slot_cnt = 0;
  int win_lo = 0, win_hi = 0;
  int errors = 0, checks = 0, cyc = 0;
  bit wd = 1'b0;
  logic prev_rx = 1'b0, prev_pres = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owire_slot_engine #(.CLK_PER_US(KUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .scale(scale), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .busy(busy), .done(done),
    .rx_bit(rx_bit), .presence(presence), .line_oe(line_oe), .line_in(line_in));

  always @(posedge clk) begin
    slot_cnt <= busy ? slot_cnt + 1 : 0;
    cyc <= cyc + 1;
    if (cyc > 190000) wd <= 1'b1;
  end
  assign dev_low = busy && (slot_cnt >= win_lo) && (slot_cnt < win_hi);
  assign line_in = !(line_oe || dev_low);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_low(input logic [1:0] op, input logic b);
    if (op == 2'b00) return 500;
    if (op == 2'b10 || (op == 2'b11 && b)) return 6;
    if (op == 2'b01 && b) return 6;
    return 60;
  endfunction
  function automatic int f_wait(input logic [1:0] op, input logic b);
    if (op == 2'b00) return 70;
    if (op == 2'b10 || (op == 2'b11 && b)) return 9;
    if (op == 2'b01 && b) return 64;
    return 10;
  endfunction
  function automatic int f_tail(input logic [1:0] op, input logic b);
    if (op == 2'b00) return 430;
    if (op == 2'b10 || (op == 2'b11 && b)) return 55;
    return 0;
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic b, input int s,
                         input int lo, input int hi, input int inject, input string tag);
    int u, a, w, t, p, cnt, ocnt, dn;
    logic lvl, e_rx, e_pres;
    bit rd;
    u = KUS * ((s == 0) ? 1 : s);
    a = f_low(op, b); w = f_wait(op, b); t = f_tail(op, b);
    rd = (op == 2'b10) || (op == 2'b11 && b);
    p = (a + w) * u - 2;
    lvl = !((p >= lo) && (p < hi));
    e_rx = prev_rx; e_pres = prev_pres;
    if (op == 2'b00) e_pres = !lvl;
    else e_rx = rd ? lvl : 1'b0;
    win_lo = lo; win_hi = hi;
    @(negedge clk);
    cmd_op = op; cmd_bit = b; scale = 4'(s); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    scale = 4'($urandom_range(0, 15));
    cnt = 0; ocnt = 0; dn = 0;
    while (busy && !wd) begin
      if (line_oe) ocnt++;
      if (done) dn++;
      if (cnt == inject) begin
        cmd_valid = 1'b1; cmd_op = 2'($urandom_range(0, 3)); cmd_bit = 1'($urandom_range(0, 1));
      end else cmd_valid = 1'b0;
      cnt++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(cnt == (a + w + t) * u, {tag, " R8 busy length"}, cnt, (a + w + t) * u);
    chk(ocnt == a * u, {tag, " R9 low length"}, ocnt, a * u);
    chk(done == 1'b1 && dn == 0, {tag, " R8 done pulse"}, done, 1);
    chk(rx_bit == e_rx, {tag, " rx_bit"}, rx_bit, e_rx);
    chk(presence == e_pres, {tag, " presence"}, presence, e_pres);
    prev_rx = rx_bit; prev_pres = presence;
    @(negedge clk);
    chk(!done && !busy, {tag, " R8 idle after slot"}, {busy, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !line_oe && !rx_bit && !presence, "R1 reset state",
        {busy, done, line_oe, rx_bit, presence}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmd(2'b01, 1'b1, 1, 0, 0, -1, "R2 write1");
    run_cmd(2'b01, 1'b0, 2, 0, 0, 40, "R3 write0 stray cmd");
    run_cmd(2'b10, 1'b1, 1, 2*KUS, 30*KUS, -1, "R4 read zero");
    run_cmd(2'b10, 1'b0, 1, 0, 0, -1, "R4 read one");
    run_cmd(2'b10, 1'b0, 2, 20*2*KUS, 40*2*KUS, 10, "R4 late device");
    run_cmd(2'b00, 1'b0, 1, 520*KUS, 650*KUS, 300, "R5 reset present");
    run_cmd(2'b00, 1'b1, 1, 0, 0, -1, "R5 reset absent");
    run_cmd(2'b11, 1'b1, 1, 2*KUS, 30*KUS, -1, "R6 touch1 zero");
    run_cmd(2'b11, 1'b1, 3, 0, 0, -1, "R6 touch1 one");
    run_cmd(2'b11, 1'b0, 1, 0, 0, -1, "R6 touch0");
    run_cmd(2'b01, 1'b1, 0, 0, 0, 5, "R7 scale zero");
    run_cmd(2'b01, 1'b0, 3, 0, 0, -1, "R7 scale three");
    void'($urandom(32'd1234));
    for (int i = 0; i < 30 && !wd; i++) begin
      logic [1:0] op;
      logic b;
      int s, u, lo, hi;
      op = 2'($urandom_range(0, 3));
      if (op == 2'b00 && $urandom_range(0, 2) != 0) op = 2'b10;
      b = 1'($urandom_range(0, 1));
      s = $urandom_range(0, 3);
      u = KUS * ((s == 0) ? 1 : s);
      lo = 0; hi = 0;
      if ($urandom_range(0, 1) == 1) begin
        if (op == 2'b00) begin lo = 520*u; hi = 650*u; end
        else begin lo = 2*u; hi = 30*u; end
      end
      run_cmd(op, b, s, lo, hi, $urandom_range(1, 60), "R10 random");
    end
    if (wd) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule